// File: doc/BRIEF.md
# Quality-Scalable Bayer Colour Interpolator

This block rebuilds the two missing colour values at a red sample and at the green sample to its right, on a red/green row of a Bayer mosaic. All four 8-bit results come from a single 5-row by 6-column neighbourhood. Each result is the sum of two parts. The bilinear average of the nearest same-colour samples is formed in the first adder stages. Gradient correction terms, whose weights always sum to zero, are added in the later stages.

A two-bit quality mode picks the stage from which each output is taken. In the full mode all gradient terms are used. In the reduced mode the last correction stage is dropped. In the minimal mode only the bilinear part remains, plus, at the green site, a short balanced gradient. This lets a slow or under-volted chain still give a usable result from its early, short paths. The mode is sampled with the window on the same clock edge, and one output register follows the combinational datapath.

Every weight w/8 is applied by right-shifting the pixel before the adders, with the remainder dropped. A weight of 4/8 is a shift of 1, 2/8 is a shift of 2, 1/8 is a shift of 3, and 1/16 is a shift of 4.

Top module: `bayer_interp`

## Requirements
- R1: The pixel at row r (0 = top) and column c (0 = left) is `win[(6*r+c)*8 +: 8]`. The red centre is at (2,2) and the green centre is at (2,3). All four outputs are registered exactly one clock after the window and mode they come from. While `rst` is high on a clock edge, the outputs become 0.
- R2: Each term is the pixel shifted right with truncation, using a shift of 1 for weight 4/8, 2 for 2/8, 3 for 1/8 and 4 for 1/16. The signed sum is formed with no other rounding.
- R3: `mode` is decoded as follows: 2'b00 is full quality, 2'b01 is reduced, and any value with bit 1 set (2'b10 or 2'b11) is minimal.
- R4: In the full mode, green at red = (1,2)>>2 + (3,2)>>2 + (2,1)>>2 + (2,3)>>2 + 2·((2,2)>>2) − the four reds (0,2),(4,2),(2,0),(2,4) each >>3.
- R5: In the reduced mode, green at red keeps the four greens, one (2,2)>>2 term and only the horizontal far reds (2,0),(2,4) >>3. In the minimal mode it is the sum of the four greens >>2 alone.
- R6: Blue at red uses the diagonal blues (1,1),(1,3),(3,1),(3,3) in place of the four greens, with the same red gradient terms as green at red in every mode.
- R7: In the full mode, red at green = (2,2)>>1 + (2,4)>>1 + (2,3)>>1 + (2,3)>>3 + (0,3)>>4 + (4,3)>>4 − the greens (2,1),(2,5),(1,2),(3,4),(1,4),(3,2) each >>3.
- R8: In the reduced mode, red at green = (2,2)>>1 + (2,4)>>1 + (2,3)>>1 − the greens (2,1),(2,5),(1,2),(3,4) each >>3. This is seven taps.
- R9: In the minimal mode, the centre green is scaled by >>2 instead of >>1: red at green = (2,2)>>1 + (2,4)>>1 + (2,3)>>2 − (2,1)>>3 − (2,5)>>3.
- R10: Blue at green is red at green with the axes swapped. The near pair is the blues (1,3),(3,3). The far greens subtracted in all modes are (0,3),(4,3). The half-weight greens added in the full mode are (2,1),(2,5). The diagonal greens are the same as for red at green.
- R11: Each output is clamped after summation. A negative sum gives 0 and a sum above 255 gives 255.
- R12: A change of mode between consecutive cycles takes effect in the very next output, with no extra latency or settling cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Quality select, sampled with the window |
| win | input | 240 | 5x6 Bayer neighbourhood, 8 bits per pixel |
| g_at_r | output | 8 | Green estimate at red centre (2,2) |
| b_at_r | output | 8 | Blue estimate at red centre (2,2) |
| r_at_g | output | 8 | Red estimate at green centre (2,3) |
| b_at_g | output | 8 | Blue estimate at green centre (2,3) |

## Verification
The bench drives the same window through all four mode codes back to back. A design that tapped the wrong partial sum, or that lagged a cycle behind a mode change, would then return a value belonging to a different mode. Saturated windows push the gradient sums past 255 and below zero, which would wrap instead of clamp if saturation were missing. Small flat pixel values expose any rounding that differs from per-term truncation. Random windows biased toward 0 and 255 catch swapped taps or axes, above all at the green site, where the red and blue filters are transposes of each other.

// File: rtl/bayer_pkg.sv
`timescale 1ns/1ps
package bayer_pkg;
    localparam int PIX_W    = 8;
    localparam int WIN_ROWS = 5;
    localparam int WIN_COLS = 6;
    localparam int WIN_BITS = PIX_W * WIN_ROWS * WIN_COLS;
    localparam int GUARD_W  = 3;
    localparam int ACC_W    = PIX_W + GUARD_W;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;

    // shift amounts realising weight/8
    localparam int SH_W4 = 1;
    localparam int SH_W2 = 2;
    localparam int SH_W1 = 3;
    localparam int SH_WH = 4;

    // window coordinates of the two target sites
    localparam int ROW_C = 2;
    localparam int COL_R = 2;
    localparam int COL_G = 3;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        TAP_FULL = 2'd0,
        TAP_MID  = 2'd1,
        TAP_BIL  = 2'd2
    } tap_sel_e;

    typedef struct packed {
        pix_t g_at_r;
        pix_t b_at_r;
        pix_t r_at_g;
        pix_t b_at_g;
    } site_out_t;

    function automatic tap_sel_e decode_mode(input logic [1:0] m);
        if (m[1]) return TAP_BIL;
        if (m[0]) return TAP_MID;
        return TAP_FULL;
    endfunction

    // weight applied as a truncating shift ahead of the adders
    function automatic acc_t tap(input pix_t p, input int sh);
        logic [ACC_W-1:0] wide;
        wide = ACC_W'(p);
        return $signed(wide >> sh);
    endfunction

    function automatic pix_t clamp_pix(input acc_t v);
        if (v < 0) return '0;
        if (v > acc_t'(PIX_MAX)) return pix_t'(PIX_MAX);
        return v[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/quality_tap_mux.sv
`timescale 1ns/1ps
module quality_tap_mux
    import bayer_pkg::*;
(
    input  tap_sel_e sel,
    input  acc_t     full_sum,
    input  acc_t     mid_sum,
    input  acc_t     bil_sum,
    output acc_t     y
);
    always_comb begin
        unique case (sel)
            TAP_BIL: y = bil_sum;
            TAP_MID: y = mid_sum;
            default: y = full_sum;
        endcase
    end
endmodule

// File: rtl/red_site_filter.sv
`timescale 1ns/1ps
module red_site_filter
    import bayer_pkg::*;
(
    input  tap_sel_e   sel,
    input  pix_t [3:0] nb,       // four bilinear neighbours, weight 2
    input  pix_t       centre,   // centre red
    input  pix_t [1:0] far_h,    // horizontal reds at distance two
    input  pix_t [1:0] far_v,    // vertical reds at distance two
    output acc_t       y
);
    acc_t s1, s2, s3, s4;

    always_comb begin
        s1 = tap(nb[0], SH_W2) + tap(nb[1], SH_W2);
        s2 = s1 + tap(nb[2], SH_W2) + tap(nb[3], SH_W2);          // bilinear
        s3 = s2 + tap(centre, SH_W2) - tap(far_h[0], SH_W1) - tap(far_h[1], SH_W1);
        s4 = s3 + tap(centre, SH_W2) - tap(far_v[0], SH_W1) - tap(far_v[1], SH_W1);
    end

    quality_tap_mux u_mux (
        .sel      (sel),
        .full_sum (s4),
        .mid_sum  (s3),
        .bil_sum  (s2),
        .y        (y)
    );
endmodule

// File: rtl/green_site_filter.sv
`timescale 1ns/1ps
module green_site_filter
    import bayer_pkg::*;
(
    input  tap_sel_e   sel,
    input  pix_t [1:0] near,     // same-colour pair, weight 4
    input  pix_t       centre,   // centre green
    input  pix_t [1:0] far_a,    // distance-two greens, weight -1, all modes
    input  pix_t [1:0] far_b,    // distance-two greens, weight +1/2, full only
    input  pix_t [1:0] diag_a,   // diagonal greens from the reduced mode on
    input  pix_t [1:0] diag_b,   // diagonal greens in the full mode only
    output acc_t       y
);
    acc_t cg, s1, s2, s3, s4;

    always_comb begin
        // centre weight scaled so each mode keeps a zero-sum gradient
        cg = (sel == TAP_BIL) ? tap(centre, SH_W2) : tap(centre, SH_W4);
        s1 = tap(near[0], SH_W4) + tap(near[1], SH_W4);           // bilinear
        s2 = s1 + cg - tap(far_a[0], SH_W1) - tap(far_a[1], SH_W1);
        s3 = s2 - tap(diag_a[0], SH_W1) - tap(diag_a[1], SH_W1);
        s4 = s3 + tap(centre, SH_W1) + tap(far_b[0], SH_WH) + tap(far_b[1], SH_WH)
                - tap(diag_b[0], SH_W1) - tap(diag_b[1], SH_W1);
    end

    quality_tap_mux u_mux (
        .sel      (sel),
        .full_sum (s4),
        .mid_sum  (s3),
        .bil_sum  (s2),
        .y        (y)
    );
endmodule

// File: rtl/bayer_interp.sv
`timescale 1ns/1ps
module bayer_interp
    import bayer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode,
    input  logic [WIN_BITS-1:0] win,
    output logic [PIX_W-1:0]    g_at_r,
    output logic [PIX_W-1:0]    b_at_r,
    output logic [PIX_W-1:0]    r_at_g,
    output logic [PIX_W-1:0]    b_at_g
);
    localparam int N_SITE_OUT = 2;

    pix_t     px [WIN_ROWS][WIN_COLS];
    tap_sel_e sel;

    always_comb begin
        for (int r = 0; r < WIN_ROWS; r++) begin
            for (int c = 0; c < WIN_COLS; c++) begin
                px[r][c] = win[(r*WIN_COLS + c)*PIX_W +: PIX_W];
            end
        end
    end

    assign sel = decode_mode(mode);

    // red site: index 0 = green estimate, 1 = blue estimate
    pix_t [N_SITE_OUT-1:0][3:0] rs_nb;
    pix_t [1:0]                 rs_far_h, rs_far_v;
    acc_t                       rs_y [N_SITE_OUT];

    assign rs_nb[0]  = {px[ROW_C-1][COL_R], px[ROW_C+1][COL_R],
                        px[ROW_C][COL_R-1], px[ROW_C][COL_R+1]};
    assign rs_nb[1]  = {px[ROW_C-1][COL_R-1], px[ROW_C-1][COL_R+1],
                        px[ROW_C+1][COL_R-1], px[ROW_C+1][COL_R+1]};
    assign rs_far_h  = {px[ROW_C][COL_R-2], px[ROW_C][COL_R+2]};
    assign rs_far_v  = {px[ROW_C-2][COL_R], px[ROW_C+2][COL_R]};

    for (genvar k = 0; k < N_SITE_OUT; k++) begin : g_red_site
        red_site_filter u_filt (
            .sel    (sel),
            .nb     (rs_nb[k]),
            .centre (px[ROW_C][COL_R]),
            .far_h  (rs_far_h),
            .far_v  (rs_far_v),
            .y      (rs_y[k])
        );
    end

    // green site: index 0 = red estimate, 1 = blue estimate (axes swapped)
    pix_t [N_SITE_OUT-1:0][1:0] gs_near, gs_far_a, gs_far_b;
    pix_t [1:0]                 gs_diag_a, gs_diag_b;
    pix_t [1:0]                 g_horiz2, g_vert2;
    acc_t                       gs_y [N_SITE_OUT];

    assign g_horiz2    = {px[ROW_C][COL_G-2], px[ROW_C][COL_G+2]};
    assign g_vert2     = {px[ROW_C-2][COL_G], px[ROW_C+2][COL_G]};
    assign gs_near[0]  = {px[ROW_C][COL_G-1], px[ROW_C][COL_G+1]};
    assign gs_near[1]  = {px[ROW_C-1][COL_G], px[ROW_C+1][COL_G]};
    assign gs_far_a[0] = g_horiz2;
    assign gs_far_b[0] = g_vert2;
    assign gs_far_a[1] = g_vert2;
    assign gs_far_b[1] = g_horiz2;
    assign gs_diag_a   = {px[ROW_C-1][COL_G-1], px[ROW_C+1][COL_G+1]};
    assign gs_diag_b   = {px[ROW_C-1][COL_G+1], px[ROW_C+1][COL_G-1]};

    for (genvar k = 0; k < N_SITE_OUT; k++) begin : g_green_site
        green_site_filter u_filt (
            .sel    (sel),
            .near   (gs_near[k]),
            .centre (px[ROW_C][COL_G]),
            .far_a  (gs_far_a[k]),
            .far_b  (gs_far_b[k]),
            .diag_a (gs_diag_a),
            .diag_b (gs_diag_b),
            .y      (gs_y[k])
        );
    end

    site_out_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.g_at_r <= clamp_pix(rs_y[0]);
            q.b_at_r <= clamp_pix(rs_y[1]);
            q.r_at_g <= clamp_pix(gs_y[0]);
            q.b_at_g <= clamp_pix(gs_y[1]);
        end
    end

    assign g_at_r = q.g_at_r;
    assign b_at_r = q.b_at_r;
    assign r_at_g = q.r_at_g;
    assign b_at_g = q.b_at_g;
endmodule

// File: rtl/bayer_interp_checker.sv
`timescale 1ns/1ps
module bayer_interp_checker
    import bayer_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode,
    input logic [WIN_BITS-1:0] win,
    input logic [PIX_W-1:0]    g_at_r,
    input logic [PIX_W-1:0]    b_at_r,
    input logic [PIX_W-1:0]    r_at_g,
    input logic [PIX_W-1:0]    b_at_g
);
    function automatic int idx(input int r, input int c);
        return (r*WIN_COLS + c)*PIX_W;
    endfunction

    pix_t p03, p11, p12, p13, p21, p22, p23, p24, p25, p31, p32, p33, p43;
    assign p03 = win[idx(0,3) +: PIX_W];
    assign p11 = win[idx(1,1) +: PIX_W];
    assign p12 = win[idx(1,2) +: PIX_W];
    assign p13 = win[idx(1,3) +: PIX_W];
    assign p21 = win[idx(2,1) +: PIX_W];
    assign p22 = win[idx(2,2) +: PIX_W];
    assign p23 = win[idx(2,3) +: PIX_W];
    assign p24 = win[idx(2,4) +: PIX_W];
    assign p25 = win[idx(2,5) +: PIX_W];
    assign p31 = win[idx(3,1) +: PIX_W];
    assign p32 = win[idx(3,2) +: PIX_W];
    assign p33 = win[idx(3,3) +: PIX_W];
    assign p43 = win[idx(4,3) +: PIX_W];

    logic [PIX_W+1:0] bil_g;
    assign bil_g = (PIX_W+2)'(p12 >> 2) + (PIX_W+2)'(p32 >> 2)
                 + (PIX_W+2)'(p21 >> 2) + (PIX_W+2)'(p23 >> 2);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1: unchanged inputs give unchanged outputs one cycle on
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (armed && $stable(win) && $stable(mode)) |=>
        ($stable(g_at_r) && $stable(b_at_r) && $stable(r_at_g) && $stable(b_at_g)));

    // R5: minimal mode gives the plain bilinear green
    assert_bilinear_only_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 || mode == 2'b11) |=> ({2'b00, g_at_r} == $past(bil_g)));

    // R6: identical neighbour sets give identical red-site estimates
    assert_shared_gradient_R6: assert property (@(posedge clk) disable iff (rst)
        (p12 == p11 && p32 == p13 && p21 == p31 && p23 == p33) |=> (g_at_r == b_at_r));

    // R10: a window symmetric under the axis swap gives equal green-site estimates
    assert_transpose_R10: assert property (@(posedge clk) disable iff (rst)
        (p22 == p13 && p24 == p33 && p21 == p03 && p25 == p43) |=> (r_at_g == b_at_g));
endmodule

bind bayer_interp bayer_interp_checker u_chk (.*);

// File: tb/bayer_interp_bench.sv
`timescale 1ns/1ps
module bayer_interp_bench;
    import bayer_pkg::*;

    localparam int HALF_NS  = 2;
    localparam int N_RANDOM = 600;
    localparam int WATCHDOG = 20000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [1:0]          mode = 2'b00;
    logic [WIN_BITS-1:0] win = '0;
    logic [PIX_W-1:0]    g_at_r, b_at_r, r_at_g, b_at_g;

    bayer_interp u_bayer_interp (
        .clk(clk), .rst(rst), .mode(mode), .win(win),
        .g_at_r(g_at_r), .b_at_r(b_at_r), .r_at_g(r_at_g), .b_at_g(b_at_g)
    );

    always #HALF_NS clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        int       due;
        logic [1:0] m;
        int       eg, eb, erg, ebg;
    } exp_t;
    exp_t sb[$];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model from the requirements ----------------
    function automatic int P(input logic [WIN_BITS-1:0] w, input int r, input int c);
        return int'(w[(r*WIN_COLS + c)*PIX_W +: PIX_W]);
    endfunction

    function automatic int clip(input int v);   // R11
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // R4 R5 R6: red-site estimate from four neighbours
    function automatic int ref_red_site(input logic [WIN_BITS-1:0] w, input logic [1:0] m, input bit blue);
        int bil, mid;
        if (blue) bil = (P(w,1,1)>>2) + (P(w,1,3)>>2) + (P(w,3,1)>>2) + (P(w,3,3)>>2);
        else      bil = (P(w,1,2)>>2) + (P(w,3,2)>>2) + (P(w,2,1)>>2) + (P(w,2,3)>>2);
        if (m[1]) return clip(bil);
        mid = bil + (P(w,2,2)>>2) - (P(w,2,0)>>3) - (P(w,2,4)>>3);
        if (m[0]) return clip(mid);
        return clip(mid + (P(w,2,2)>>2) - (P(w,0,2)>>3) - (P(w,4,2)>>3));
    endfunction

    // R7 R8 R9 R10: green-site estimate, blue swaps the axes
    function automatic int ref_green_site(input logic [WIN_BITS-1:0] w, input logic [1:0] m, input bit blue);
        int n0, n1, a0, a1, b0, b1, cg, s;
        if (blue) begin
            n0 = P(w,1,3); n1 = P(w,3,3);
            a0 = P(w,0,3); a1 = P(w,4,3);
            b0 = P(w,2,1); b1 = P(w,2,5);
        end else begin
            n0 = P(w,2,2); n1 = P(w,2,4);
            a0 = P(w,2,1); a1 = P(w,2,5);
            b0 = P(w,0,3); b1 = P(w,4,3);
        end
        cg = m[1] ? (P(w,2,3)>>2) : (P(w,2,3)>>1);
        s  = (n0>>1) + (n1>>1) + cg - (a0>>3) - (a1>>3);
        if (m[1]) return clip(s);
        s = s - (P(w,1,2)>>3) - (P(w,3,4)>>3);
        if (m[0]) return clip(s);
        s = s + (P(w,2,3)>>3) + (b0>>4) + (b1>>4) - (P(w,1,4)>>3) - (P(w,3,2)>>3);
        return clip(s);
    endfunction

    // ---------------- window builders ----------------
    function automatic logic [WIN_BITS-1:0] fill(input int rv, input int gv, input int bv);
        logic [WIN_BITS-1:0] w;
        for (int r = 0; r < WIN_ROWS; r++) begin
            for (int c = 0; c < WIN_COLS; c++) begin
                int v;
                if (r % 2 == 0) v = (c % 2 == 0) ? rv : gv;
                else            v = (c % 2 == 0) ? gv : bv;
                w[(r*WIN_COLS + c)*PIX_W +: PIX_W] = PIX_W'(v);
            end
        end
        return w;
    endfunction

    function automatic logic [WIN_BITS-1:0] put(input logic [WIN_BITS-1:0] w, input int r, input int c, input int v);
        logic [WIN_BITS-1:0] o;
        o = w;
        o[(r*WIN_COLS + c)*PIX_W +: PIX_W] = PIX_W'(v);
        return o;
    endfunction

    // ---------------- driver ----------------
    task automatic drive(input logic [WIN_BITS-1:0] w, input logic [1:0] m);
        exp_t e;
        @(negedge clk);
        win  = w;
        mode = m;
        e.due = cyc + 1;
        e.m   = m;
        e.eg  = ref_red_site(w, m, 1'b0);
        e.eb  = ref_red_site(w, m, 1'b1);
        e.erg = ref_green_site(w, m, 1'b0);
        e.ebg = ref_green_site(w, m, 1'b1);
        sb.push_back(e);
    endtask

    task automatic all_modes(input logic [WIN_BITS-1:0] w);
        // R12: back-to-back mode changes on one window
        for (int m = 0; m < 4; m++) drive(w, 2'(m));
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        exp_t  e;
        string t_red, t_grn;
        if (!rst && sb.size() > 0 && sb[0].due <= cyc) begin
            e = sb.pop_front();
            t_red = e.m[1] ? "R5" : (e.m[0] ? "R5" : "R4");
            t_grn = e.m[1] ? "R9" : (e.m[0] ? "R8" : "R7");
            if (e.m == 2'b11) begin
                t_red = {t_red, " R3"};
                t_grn = {t_grn, " R3"};
            end
            check(t_red,  "g_at_r", int'(g_at_r), e.eg);
            check("R6",   "b_at_r", int'(b_at_r), e.eb);
            check(t_grn,  "r_at_g", int'(r_at_g), e.erg);
            check("R10",  "b_at_g", int'(b_at_g), e.ebg);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", WATCHDOG);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [WIN_BITS-1:0] w;

        // R1: reset clears the outputs even with a bright window
        win = fill(255, 255, 255);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "g_at_r reset", int'(g_at_r), 0);
        check("R1", "b_at_r reset", int'(b_at_r), 0);
        check("R1", "r_at_g reset", int'(r_at_g), 0);
        check("R1", "b_at_g reset", int'(b_at_g), 0);
        rst = 1'b0;

        // R2: truncation per term, flat value 7 in full mode -> 6 and 9
        drive(fill(7, 7, 7), 2'b00);
        @(negedge clk);
        check("R2", "g_at_r flat 7", int'(g_at_r), 6);
        check("R2", "r_at_g flat 7", int'(r_at_g), 9);

        // flat and edge windows through every mode (R3 R12)
        all_modes(fill(100, 100, 100));
        all_modes(fill(10, 200, 90));
        w = fill(40, 40, 40);
        for (int r = 0; r < WIN_ROWS; r++)
            for (int c = 0; c < 3; c++) w = put(w, r, c, 200);
        all_modes(w);
        w = fill(40, 40, 40);
        for (int c = 0; c < WIN_COLS; c++) w = put(put(w, 0, c, 220), 1, c, 220);
        all_modes(w);

        // R11: overflow, bright window with dark far reds
        w = fill(255, 255, 255);
        w = put(put(put(put(w, 0, 2, 0), 4, 2, 0), 2, 0, 0), 2, 4, 0);
        drive(w, 2'b00);
        @(negedge clk);
        check("R11", "g_at_r high clamp", int'(g_at_r), 255);
        all_modes(w);

        // R11: underflow at the red site
        w = fill(0, 0, 0);
        w = put(put(put(put(w, 0, 2, 255), 4, 2, 255), 2, 0, 255), 2, 4, 255);
        drive(w, 2'b00);
        @(negedge clk);
        check("R11", "g_at_r low clamp", int'(g_at_r), 0);
        all_modes(w);

        // R11: underflow at the green site
        w = put(fill(0, 255, 0), 2, 3, 0);
        drive(w, 2'b00);
        @(negedge clk);
        check("R11", "r_at_g low clamp", int'(r_at_g), 0);
        all_modes(w);

        // random windows biased to the rails, all mode codes
        for (int i = 0; i < N_RANDOM; i++) begin
            for (int k = 0; k < WIN_BITS / PIX_W; k++) begin
                int sel;
                int v;
                sel = int'($urandom_range(0, 3));
                v = (sel == 0) ? 0 : (sel == 1) ? 255 : int'($urandom_range(0, 255));
                w[k*PIX_W +: PIX_W] = PIX_W'(v);
            end
            drive(w, 2'(i % 4));
        end

        repeat (4) @(negedge clk);
        if (sb.size() != 0) check("R1", "scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule